// File: doc/BRIEF.md
# Vector Swizzle Move Index Sequencer

This block walks a vectorised swizzle move one move at a time. It is given a vector length, a source subvector length, four 3-bit lane selectors and two loop-order controls. For each move it emits a destination element offset together with either a source element offset or a request to write a constant. A downstream mover consumes one request per cycle in which it raises `step_rdy`. The sequencer does not touch register storage and does not move data.

Each destination lane position has a selector. The selector can skip the lane, mark the end of the destination subvector, request constant zero or one, or name a source lane. The destination subvector may therefore be shorter than the source subvector, or longer. The source walk and the destination walk run in lockstep, and each walk can be switched to lane-major order on its own. In vertical-first mode one start pulse releases only a bounded group of moves. The rest of the sequence waits for further start pulses.

Top module: `swz_seq`

## Requirements
- R1: While reset is asserted and after it is released, `mv_valid`, `done` and `done_all` are low until a start pulse is taken.
- R2: Selector field j occupies `sel[3j+2:3j]`. The destination subvector length is j+1 for the lowest j whose field is 001. If no field is 001, the length is 4.
- R3: Only positions below the destination subvector length whose selector is 010, 011 or 1NN produce moves. Positions coded 000 or 001 produce no move. The number of moves is the vector length times the number of such active positions.
- R4: A move whose active position is coded 010 or 011 raises `mv_const`. For 011 it also raises `mv_one`, and for 010 it lowers `mv_one`. For a constant move, `mv_src` reads 0.
- R5: With `pack_en` low, move k takes source element e = k / A and active slot s = k mod A, where A is the number of active positions. For a 1NN selector at that slot, `mv_src` is e*SUBVL + NN.
- R6: With `unpack_en` low, the destination walk uses the same element-major order, and `mv_dst` is e*D + p. Here D is the destination subvector length and p is the slot's lane position.
- R7: With `pack_en` high, the source walk is slot-major: s = k / VL and e = k mod VL. A 1NN source then reads NN*VL + e.
- R8: With `unpack_en` high, the destination walk is slot-major in the same way, and `mv_dst` is p*VL + e. Both enables may be high together.
- R9: A request held on `mv_valid` while `step_rdy` is low keeps all of its fields unchanged. Each cycle with both `mv_valid` and `step_rdy` high consumes exactly one source/destination pair.
- R10: `done` and `done_all` pulse together for one cycle, one cycle after the final pair is consumed. No move is presented after that until a new start pulse.
- R11: With `vert_first` high, each start pulse releases at most G moves, followed by a one-cycle `done` without `done_all`. G is SUBVL when `pack_en` is low, D when only `pack_en` is high, and 1 when both enables are high.
- R12: All configuration inputs are captured on the start pulse that begins a sequence. Later changes to them, including during vertical-first pauses, do not affect that sequence.
- R13: When there are no active positions, a start produces no move, and `done` with `done_all` follows two cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sequence, or resumes a paused vertical-first sequence |
| vert_first | input | 1 | Vertical-first grouping enable |
| pack_en | input | 1 | Source walk slot-major |
| unpack_en | input | 1 | Destination walk slot-major |
| vec_len | input | 7 | Vector length, 1 to 64 |
| src_sublen | input | 3 | Source subvector length, 1 to 4 |
| sel | input | 12 | Four 3-bit lane selectors |
| step_rdy | input | 1 | Mover accepts the current request |
| mv_valid | output | 1 | A move request is presented |
| mv_dst | output | 8 | Destination element offset |
| mv_src | output | 8 | Source element offset |
| mv_const | output | 1 | Request writes a constant |
| mv_one | output | 1 | Constant value is one |
| done | output | 1 | One-cycle pulse at the end of a group or of the sequence |
| done_all | output | 1 | One-cycle pulse at the end of the whole sequence |

## Verification
If an element or slot counter slips, the offset presented on the very next request is wrong. Because every request is compared against an independently computed list, the error appears within one cycle of the slip. A wrong move counter or group counter shows up either as a request presented after the list is empty or as a `done` pulse in the wrong cycle. Configuration latched in the wrong cycle changes every later offset, so the bench alters the inputs in the middle of a sequence to expose it.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int NSEL = 4;
  localparam int SELW = 3;

  typedef logic [SELW-1:0] sel_t;

  localparam sel_t SEL_END = 3'b001;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} st_e;

  // lane position of the n-th set bit of an active mask
  function automatic logic [1:0] nth_pos(input logic [NSEL-1:0] act, input logic [1:0] n);
    logic [2:0] cnt;
    nth_pos = '0;
    cnt = '0;
    for (int j = 0; j < NSEL; j++) begin
      if (act[j]) begin
        if (cnt == {1'b0, n}) nth_pos = 2'(j);
        cnt = cnt + 3'd1;
      end
    end
  endfunction
endpackage

// File: rtl/swz_rsync.sv
module swz_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta   <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta   <= 1'b1;
      srst_n <= meta;
    end
  end
endmodule

// File: rtl/swz_dec.sv
module swz_dec
  import swz_pkg::*;
(
  input  logic [NSEL*SELW-1:0] sel,
  output logic [2:0]           dlen,
  output logic [NSEL-1:0]      act,
  output logic [2:0]           nact
);
  // lowest end marker fixes the destination subvector length
  always_comb begin
    logic found;
    found = 1'b0;
    dlen  = 3'(NSEL);
    for (int j = 0; j < NSEL; j++) begin
      if (!found && sel[j*SELW +: SELW] == SEL_END) begin
        dlen  = 3'(j + 1);
        found = 1'b1;
      end
    end
  end

  for (genvar j = 0; j < NSEL; j++) begin : g_act
    assign act[j] = (3'(j) < dlen) && (sel[j*SELW+1 +: 2] != 2'b00);
  end

  always_comb begin
    nact = '0;
    for (int j = 0; j < NSEL; j++) nact = nact + {2'b00, act[j]};
  end
endmodule

// File: rtl/swz_walk.sv
module swz_walk #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic           outer,
  input  logic [VLW-1:0] vl,
  input  logic [2:0]     nact,
  output logic [VLW-1:0] elem,
  output logic [1:0]     slot
);
  logic [VLW-1:0] elem_n;
  logic [1:0]     slot_n;
  logic           en;

  assign en = clr | adv;

  always_comb begin
    elem_n = elem;
    slot_n = slot;
    if (clr) begin
      elem_n = '0;
      slot_n = '0;
    end else if (adv) begin
      if (outer) begin
        if (elem == vl - VLW'(1)) begin
          elem_n = '0;
          slot_n = slot + 2'd1;
        end else begin
          elem_n = elem + VLW'(1);
        end
      end else begin
        if ({1'b0, slot} == nact - 3'd1) begin
          slot_n = '0;
          elem_n = elem + VLW'(1);
        end else begin
          slot_n = slot + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem <= '0;
      slot <= '0;
    end else if (en) begin
      elem <= elem_n;
      slot <= slot_n;
    end
  end

  // R9: a consumed pair always refers to an existing slot and element
  assert_slot_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ({1'b0, slot} < nact) && (elem < vl));
endmodule

// File: rtl/swz_seq.sv
module swz_seq
  import swz_pkg::*;
#(
  parameter int VL_MAX = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        vert_first,
  input  logic        pack_en,
  input  logic        unpack_en,
  input  logic [6:0]  vec_len,
  input  logic [2:0]  src_sublen,
  input  logic [11:0] sel,
  input  logic        step_rdy,
  output logic        mv_valid,
  output logic [7:0]  mv_dst,
  output logic [7:0]  mv_src,
  output logic        mv_const,
  output logic        mv_one,
  output logic        done,
  output logic        done_all
);
  localparam int VLW  = $clog2(VL_MAX + 1);
  localparam int IDXW = $clog2(VL_MAX * NSEL);
  localparam int TOTW = $clog2(VL_MAX * NSEL + 1);

  logic srst_n;
  swz_rsync u_rsync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  // captured configuration
  logic [VLW-1:0]       c_vl;
  logic [2:0]           c_sub;
  logic [NSEL*SELW-1:0] c_sel;
  logic                 c_pack, c_unpack, c_vf;

  st_e            st, st_n;
  logic [TOTW-1:0] k, k_n;
  logic [2:0]      grp, grp_n;
  logic            done_n, dall_n, lat, clr, adv;

  logic [2:0]      dlen, nact, gsize;
  logic [NSEL-1:0] act;
  logic [TOTW-1:0] total;
  logic [VLW-1:0]  s_elem, d_elem;
  logic [1:0]      s_slot, d_slot, s_pos, d_pos;
  sel_t            s_code;

  swz_dec u_dec (.sel(c_sel), .dlen(dlen), .act(act), .nact(nact));

  swz_walk #(.VLW(VLW)) u_src_walk (
    .clk(clk), .rst_n(srst_n), .clr(clr), .adv(adv), .outer(c_pack),
    .vl(c_vl), .nact(nact), .elem(s_elem), .slot(s_slot));

  swz_walk #(.VLW(VLW)) u_dst_walk (
    .clk(clk), .rst_n(srst_n), .clr(clr), .adv(adv), .outer(c_unpack),
    .vl(c_vl), .nact(nact), .elem(d_elem), .slot(d_slot));

  assign total = TOTW'(c_vl) * TOTW'(nact);
  assign gsize = c_pack ? (c_unpack ? 3'd1 : dlen) : c_sub;

  // offset formation
  assign s_pos  = nth_pos(act, s_slot);
  assign d_pos  = nth_pos(act, d_slot);
  assign s_code = c_sel[SELW*s_pos +: SELW];

  always_comb begin
    if (!s_code[2])  mv_src = '0;
    else if (c_pack) mv_src = IDXW'(s_code[1:0]) * IDXW'(c_vl) + IDXW'(s_elem);
    else             mv_src = IDXW'(s_elem) * IDXW'(c_sub) + IDXW'(s_code[1:0]);
  end

  always_comb begin
    if (c_unpack) mv_dst = IDXW'(d_pos) * IDXW'(c_vl) + IDXW'(d_elem);
    else          mv_dst = IDXW'(d_elem) * IDXW'(dlen) + IDXW'(d_pos);
  end

  assign mv_const = !s_code[2];
  assign mv_one   = !s_code[2] && s_code[0];
  assign mv_valid = (st == ST_RUN) && (nact != 3'd0);
  assign adv      = mv_valid && step_rdy;

  // next state
  always_comb begin
    st_n   = st;
    k_n    = k;
    grp_n  = grp;
    done_n = 1'b0;
    dall_n = 1'b0;
    lat    = 1'b0;
    clr    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          lat   = 1'b1;
          clr   = 1'b1;
          k_n   = '0;
          grp_n = '0;
          st_n  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (nact == 3'd0) begin
          done_n = 1'b1;
          dall_n = 1'b1;
          st_n   = ST_IDLE;
        end else if (step_rdy) begin
          k_n   = k + TOTW'(1);
          grp_n = grp + 3'd1;
          if (k == total - TOTW'(1)) begin
            done_n = 1'b1;
            dall_n = 1'b1;
            st_n   = ST_IDLE;
          end else if (c_vf && (grp + 3'd1 == gsize)) begin
            done_n = 1'b1;
            grp_n  = '0;
            st_n   = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (start) st_n = ST_RUN;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st       <= ST_IDLE;
      k        <= '0;
      grp      <= '0;
      done     <= 1'b0;
      done_all <= 1'b0;
    end else begin
      st       <= st_n;
      k        <= k_n;
      grp      <= grp_n;
      done     <= done_n;
      done_all <= dall_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      c_vl     <= VLW'(1);
      c_sub    <= 3'd1;
      c_sel    <= '0;
      c_pack   <= 1'b0;
      c_unpack <= 1'b0;
      c_vf     <= 1'b0;
    end else if (lat) begin
      c_vl     <= vec_len;
      c_sub    <= src_sublen;
      c_sel    <= sel;
      c_pack   <= pack_en;
      c_unpack <= unpack_en;
      c_vf     <= vert_first;
    end
  end

  // R9: a stalled request keeps every field
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!srst_n)
    mv_valid && !step_rdy |=> mv_valid && $stable(mv_dst) && $stable(mv_src)
                              && $stable(mv_const) && $stable(mv_one));

  // R10: sequence end is also a burst end and no request is shown with it
  assert_end_pulse_R10: assert property (@(posedge clk) disable iff (!srst_n)
    done_all |-> done && !mv_valid);

  // R11: a burst that ends before the sequence only exists in vertical-first
  assert_group_end_R11: assert property (@(posedge clk) disable iff (!srst_n)
    done && !done_all |-> c_vf);

  // R6: destination offset stays inside the destination vector
  assert_dst_range_R6: assert property (@(posedge clk) disable iff (!srst_n)
    mv_valid |-> TOTW'(mv_dst) < TOTW'(c_vl) * TOTW'(dlen));

  // R4: constant requests carry a zero source offset
  assert_const_src_R4: assert property (@(posedge clk) disable iff (!srst_n)
    mv_valid && mv_const |-> mv_src == '0);
endmodule

// File: tb/sim_swz_seq.sv
module sim_swz_seq;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vf = 1'b0, pk = 1'b0, up = 1'b0, rdy = 1'b0;
  logic [6:0]  vl = 7'd1;
  logic [2:0]  sv = 3'd1;
  logic [11:0] sel = '0;
  logic        mv_valid, mv_const, mv_one, done, done_all;
  logic [7:0]  mv_dst, mv_src;

  swz_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vert_first(vf), .pack_en(pk),
    .unpack_en(up), .vec_len(vl), .src_sublen(sv), .sel(sel), .step_rdy(rdy),
    .mv_valid(mv_valid), .mv_dst(mv_dst), .mv_src(mv_src), .mv_const(mv_const),
    .mv_one(mv_one), .done(done), .done_all(done_all));

  always #(CLK_NS/2) clk = ~clk;

  int  n_cmp = 0, n_bad = 0, cyc = 0, gsz = 0, grp_left = 0;
  int  q[$];
  bit  in_reset = 1'b1, m_run = 1'b0, m_hold = 1'b0, m_vf = 1'b0;
  bit  exp_d = 1'b0, exp_da = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [11:0] mk(input int x, input int y, input int z, input int w);
    return {3'(w), 3'(z), 3'(y), 3'(x)};
  endfunction

  // reference list: item = {const, one, src[7:0], dst[7:0]}
  function automatic void build(input int nvl, input int nsv, input logic [11:0] s,
                                input bit p, input bit u);
    int dl, na, code, se, ss, de, ds, src, dst, item;
    int pos[$];
    dl = 4;
    for (int j = 0; j < 4; j++) if (s[3*j +: 3] == 3'b001) begin dl = j + 1; break; end
    for (int j = 0; j < dl; j++) if (s[3*j +: 3] >= 3'b010) pos.push_back(j);
    na = pos.size();
    q.delete();
    gsz = p ? (u ? 1 : dl) : nsv;
    for (int k = 0; k < nvl * na; k++) begin
      if (p) begin ss = k / nvl; se = k % nvl; end else begin se = k / na; ss = k % na; end
      if (u) begin ds = k / nvl; de = k % nvl; end else begin de = k / na; ds = k % na; end
      code = int'(s[3*pos[ss] +: 3]);
      if (code >= 4) begin
        src  = p ? (code % 4) * nvl + se : se * nsv + (code % 4);
        item = src << 8;
      end else begin
        item = (1 << 17) | ((code % 2) << 16);
      end
      dst = u ? pos[ds] * nvl + de : de * dl + pos[ds];
      q.push_back(item | dst);
    end
  endfunction

  task automatic fail_msg(input string req, input int act_v, input int exp_v);
    n_bad++;
    $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act_v, exp_v);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // cycle reference model, compared every clock
  always @(negedge clk) begin
    bit nd, nda, expv;
    int e;
    nd = 1'b0;
    nda = 1'b0;
    cyc++;
    if (cyc > 100000) begin
      fail_msg("watchdog", cyc, 0);
      summary();
    end
    if (in_reset) begin
      n_cmp++;  // R1 reset state
      if (mv_valid !== 1'b0 || done !== 1'b0 || done_all !== 1'b0)
        fail_msg("R1", int'({mv_valid, done, done_all}), 0);
    end else begin
      if (start) begin
        if (!m_run) begin
          build(int'(vl), int'(sv), sel, pk, up);   // R12 capture on start
          m_vf = vf;
          grp_left = gsz;
          m_hold = 1'b0;
          m_run = 1'b1;
          if (q.size() == 0) begin                    // R13
            nd = 1'b1; nda = 1'b1; m_run = 1'b0;
          end
        end else if (m_hold) begin
          m_hold = 1'b0;
          grp_left = gsz;
        end
      end
      expv = m_run && !m_hold && (q.size() > 0);
      n_cmp++;
      if (mv_valid !== expv) fail_msg("R3/R9 valid", int'(mv_valid), int'(expv));
      if (expv && mv_valid === 1'b1) begin
        e = q[0];
        n_cmp++;
        if (mv_dst !== 8'(e)) fail_msg("R6 or R8 dst", int'(mv_dst), e % 256);
        n_cmp++;
        if (mv_src !== 8'(e >> 8)) fail_msg("R5 or R7 src", int'(mv_src), (e >> 8) % 256);
        n_cmp++;
        if ({mv_const, mv_one} !== 2'(e >> 16))
          fail_msg("R4 const", int'({mv_const, mv_one}), (e >> 16) % 4);
      end
      n_cmp++;
      if (done !== exp_d || done_all !== exp_da)
        fail_msg("R10/R11 done", int'({done, done_all}), int'({exp_d, exp_da}));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[0] | lfsr[3];
      if (expv && rdy) begin
        void'(q.pop_front());
        grp_left--;
        if (q.size() == 0) begin
          nd = 1'b1; nda = 1'b1; m_run = 1'b0;
        end else if (m_vf && grp_left == 0) begin
          nd = 1'b1; m_hold = 1'b1;
        end
      end
    end
    exp_d = nd;
    exp_da = nda;
  end

  task automatic run_seq(input int a_vl, input int a_sv, input logic [11:0] a_sel,
                         input bit a_pk, input bit a_up, input bit a_vf, input bit perturb);
    @(negedge clk); #1;
    vl = 7'(a_vl); sv = 3'(a_sv); sel = a_sel; pk = a_pk; up = a_up; vf = a_vf;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (perturb) begin   // R12: inputs change after capture
      vl = 7'd9; sv = 3'd1; sel = mk(7, 0, 2, 1); pk = ~a_pk; up = ~a_up; vf = ~a_vf;
    end
    forever begin
      @(negedge clk); #2;
      if (done_all) break;
      if (done) begin
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    in_reset = 1'b0;
    repeat (4) @(negedge clk);
    run_seq(3, 4, mk(4, 6, 7, 5), 0, 0, 0, 1);  // R5 R6 R12 all copies, perturbed
    run_seq(5, 3, mk(6, 3, 1, 7), 0, 0, 0, 0);  // R2 marker at lane 2, R4 constant one
    run_seq(4, 2, mk(5, 0, 4, 2), 1, 0, 0, 0);  // R3 skip lane, R7 pack
    run_seq(4, 2, mk(5, 0, 4, 2), 0, 1, 0, 0);  // R8 unpack
    run_seq(4, 2, mk(5, 0, 4, 2), 1, 1, 0, 0);  // R7 R8 both
    run_seq(3, 2, mk(4, 5, 2, 7), 0, 0, 1, 0);  // R11 groups of SUBVL
    run_seq(3, 2, mk(4, 3, 1, 0), 1, 0, 1, 0);  // R11 groups of dest length
    run_seq(2, 3, mk(7, 6, 5, 4), 1, 1, 1, 1);  // R11 single moves, R12 in pauses
    run_seq(4, 2, mk(0, 0, 0, 0), 0, 0, 0, 0);  // R13 all skipped
    run_seq(2, 2, mk(1, 4, 4, 4), 0, 0, 1, 0);  // R13 marker at lane 0
    run_seq(1, 1, mk(3, 2, 0, 1), 0, 0, 0, 0);  // R2 marker at lane 3, R4 constants
    run_seq(64, 4, mk(7, 4, 5, 6), 1, 0, 0, 0); // R7 full length
    run_seq(64, 4, mk(6, 2, 7, 4), 0, 1, 1, 0); // R8 R10 full length grouped
    repeat (4) @(negedge clk);                  // R10 nothing after the end
    summary();
  end
endmodule